// File: doc/BRIEF.md
# Line-State Source and Loopback Mux

This block sits on a 10-bit symbol path between the upper transmit logic, the line encoder and the receive side. It chooses what goes out on the transmit path. While the connection manager is in maintenance, that is a fixed line-state symbol or the caller's own transmit data. At all other times it is the transmit data, or the received symbols when remote loopback is on. It also chooses what appears on the receive output: the received symbols, the transmit path folded back (local loopback), or the incoming transmit stream (station bypass).

A 16-bit control register holds the routing switches and the pin-level controls for the transmitter-off and external-loopback pins, the repeat-filter enable and the self-test start. It also holds a software reset bit. That bit is combined with the power reset to form the internal reset that the rest of the chip uses. Both symbol outputs are registered, so each one shows the selection made one clock earlier.

Top module: `lsrc_loop_mux`

## Requirements
- R1: `int_rst_n` is low exactly when `pwr_rst_n` is low or control bit 8 (active-low software reset) reads 0.
- R2: A clock edge with internal reset asserted leaves the control register with bit 3 (bypass) set and bits 7, 6, 5, 4, 2 and 0 clear. Power reset also sets bit 8, so the register reads 0x0108. During software reset a write changes only bit 8.
- R3: Outside reset, a write stores bits 8, 7, 6, 5, 4, 3, 2 and 0. Bits 15:9 and 1 read 0. `fot_off`, `ext_loop_pin`, `rpt_filt_en` and `selftest_run` follow bits 7, 6, 2 and 0.
- R4: In maintenance (`mgr_in_maint`=1) with no remote loopback in effect, `tx_sym_out` shows one cycle later the symbol picked by `maint_ls_sel`: 000 QUIET (0x000), 001 IDLE (0x3FF), 010 HALT (0x084), 011 MASTER (0x098), 100 JK (0x311), 101 `tx_sym_in`.
- R5: Select codes 110 and 111 transmit the QUIET symbol.
- R6: Outside maintenance with no remote loopback in effect, `tx_sym_out` equals `tx_sym_in` of the previous cycle.
- R7: With bit 4 (remote loopback) set and local loopback not in effect, `tx_sym_out` equals `rx_sym_in` of the previous cycle.
- R8: Bit 5 (local loopback) takes effect only when `mgr_in_off` or `mgr_in_maint` is 1. It then makes `rx_sym_out` the previous cycle's transmit-path value, which is the maintenance source in maintenance and `tx_sym_in` otherwise. In any other manager state it is ignored, and `rx_sym_out` follows `rx_sym_in`.
- R9: When local loopback is in effect, remote loopback is suppressed. The transmit path then never carries `rx_sym_in`.
- R10: With bit 3 (bypass) set, `rx_sym_out` equals `tx_sym_in` of the previous cycle, whatever the loopback bits are.
- R11: The edge after a cycle with internal reset asserted leaves `tx_sym_out` at QUIET (0x000) and `rx_sym_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Synchronous active-low power reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 16 | Control register write value |
| ctl_rd_data | output | 16 | Control register read value |
| int_rst_n | output | 1 | Internal active-low reset (power or software) |
| mgr_in_off | input | 1 | Connection manager is in OFF |
| mgr_in_maint | input | 1 | Connection manager is in MAINTENANCE |
| maint_ls_sel | input | 3 | Maintenance line-state select |
| tx_sym_in | input | 10 | Transmit symbols from upper logic |
| rx_sym_in | input | 10 | Received symbols from decoder side |
| tx_sym_out | output | 10 | Registered transmit-path symbol |
| rx_sym_out | output | 10 | Registered receive-output symbol |
| fot_off | output | 1 | Transmitter-off pin |
| ext_loop_pin | output | 1 | External loopback control pin |
| rpt_filt_en | output | 1 | Repeat filter enable |
| selftest_run | output | 1 | Self-test start |

## Verification
Assertions check four things on every cycle. A software-reset write forces the internal reset. Any cycle in internal reset restores the control defaults and the QUIET/zero symbol outputs. Bypass and remote loopback each forward the right input one cycle later. Undefined select codes give QUIET, and local loopback outside OFF and MAINTENANCE leaves the receive path alone. Only the bench scenarios can show the full routing priority when several switches are set at once, the exact symbol for each maintenance code, the read-back masking and the recovery from software reset, because it compares every output on every cycle against a model of the register and the mux.

// File: rtl/lsl_pkg.sv
// Package lsl_pkg
// Shared widths, bit positions and types for the line-state source and
// loopback mux. Assumes a 16-bit control word with fixed bit positions.
package lsl_pkg;

    localparam int CTL_W = 16;

    // Control word bit positions (software depends on these).
    localparam int B_SOFT_RST_N = 8;
    localparam int B_TX_OFF     = 7;
    localparam int B_EXT_LOOP   = 6;
    localparam int B_LOC_LOOP   = 5;
    localparam int B_REM_LOOP   = 4;
    localparam int B_BYPASS     = 3;
    localparam int B_RF_EN      = 2;
    localparam int B_BIST_RUN   = 0;

    // Maintenance line-state select codes.
    typedef enum logic [2:0] {
        LS_QUIET  = 3'd0,
        LS_IDLE   = 3'd1,
        LS_HALT   = 3'd2,
        LS_MASTER = 3'd3,
        LS_JK     = 3'd4,
        LS_PASS   = 3'd5,
        LS_RSV6   = 3'd6,
        LS_RSV7   = 3'd7
    } ls_sel_e;

    // Stored control fields.
    typedef struct packed {
        logic soft_rst_n;
        logic tx_off;
        logic ext_loop;
        logic loc_loop;
        logic rem_loop;
        logic bypass;
        logic rf_en;
        logic bist_run;
    } ctl_t;

    // Value of the non-reset fields after internal reset.
    localparam ctl_t CTL_RST = '{soft_rst_n: 1'b1, tx_off: 1'b0, ext_loop: 1'b0,
                                 loc_loop: 1'b0, rem_loop: 1'b0, bypass: 1'b1,
                                 rf_en: 1'b0, bist_run: 1'b0};

endpackage

// File: rtl/lsl_ctl_reg.sv
// Module lsl_ctl_reg
// Holds the control word and forms the internal reset from the power reset
// and the software reset bit. Assumes pwr_rst_n is synchronous and active low.
// The software reset bit is cleared only by a write and set by power reset.
// While it is asserted, the other fields keep their reset values and a write
// changes only the software reset bit.
module lsl_ctl_reg
    import lsl_pkg::*;
(
    input  logic             clk,
    input  logic             pwr_rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output ctl_t             ctl,
    output logic [CTL_W-1:0] rd_data,
    output logic             int_rst_n
);

    ctl_t ctl_q;
    ctl_t ctl_d;
    ctl_t wr_fields;

    logic unused_wr;
    assign unused_wr = ^{wr_data[CTL_W-1:B_SOFT_RST_N+1], wr_data[1]};

    // Unpack the write value into the stored fields.
    always_comb begin
        wr_fields.soft_rst_n = wr_data[B_SOFT_RST_N];
        wr_fields.tx_off     = wr_data[B_TX_OFF];
        wr_fields.ext_loop   = wr_data[B_EXT_LOOP];
        wr_fields.loc_loop   = wr_data[B_LOC_LOOP];
        wr_fields.rem_loop   = wr_data[B_REM_LOOP];
        wr_fields.bypass     = wr_data[B_BYPASS];
        wr_fields.rf_en      = wr_data[B_RF_EN];
        wr_fields.bist_run   = wr_data[B_BIST_RUN];
    end

    // Next-state of the control word, holding fields at reset while soft reset is on.
    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d = wr_fields;
        end
        if (!ctl_q.soft_rst_n) begin
            ctl_d = CTL_RST;
            ctl_d.soft_rst_n = wr_en ? wr_fields.soft_rst_n : 1'b0;
        end
    end

    // Control word storage; power reset restores every field.
    always_ff @(posedge clk) begin
        if (!pwr_rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Read-back word with undefined positions as zero.
    always_comb begin
        rd_data = '0;
        rd_data[B_SOFT_RST_N] = ctl_q.soft_rst_n;
        rd_data[B_TX_OFF]     = ctl_q.tx_off;
        rd_data[B_EXT_LOOP]   = ctl_q.ext_loop;
        rd_data[B_LOC_LOOP]   = ctl_q.loc_loop;
        rd_data[B_REM_LOOP]   = ctl_q.rem_loop;
        rd_data[B_BYPASS]     = ctl_q.bypass;
        rd_data[B_RF_EN]      = ctl_q.rf_en;
        rd_data[B_BIST_RUN]   = ctl_q.bist_run;
    end

    assign ctl       = ctl_q;
    assign int_rst_n = pwr_rst_n & ctl_q.soft_rst_n;

    // R1: a write clearing the soft reset bit asserts the internal reset next cycle.
    a_r1_soft_write_resets: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (wr_en && !wr_data[B_SOFT_RST_N]) |=> !int_rst_n);

    // R2: after a cycle in internal reset, defaults are in place.
    a_r2_defaults_after_reset: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        !$past(int_rst_n) |-> (ctl_q.bypass && !ctl_q.tx_off && !ctl_q.ext_loop &&
                               !ctl_q.loc_loop && !ctl_q.rem_loop && !ctl_q.rf_en &&
                               !ctl_q.bist_run));

    // R3: undefined positions never read as one.
    a_r3_rsv_zero: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (rd_data[CTL_W-1:B_SOFT_RST_N+1] == '0) && !rd_data[1]);

endmodule

// File: rtl/lsl_rx_route.sv
// Module lsl_rx_route
// Decides which loopbacks are in effect and drives the registered receive
// output: bypass first, then local loopback, then the received symbols.
// Assumes tx_path is the transmit path before any remote loopback.
module lsl_rx_route #(
    parameter int SYM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass,
    input  logic             loc_loop,
    input  logic             rem_loop,
    input  logic             mgr_off,
    input  logic             mgr_maint,
    input  logic [SYM_W-1:0] tx_in,
    input  logic [SYM_W-1:0] rx_in,
    input  logic [SYM_W-1:0] tx_path,
    output logic             loc_eff,
    output logic             rem_eff,
    output logic [SYM_W-1:0] rx_q
);

    logic [SYM_W-1:0] rx_d;

    // Local loop is honoured only in OFF or MAINTENANCE and beats remote loop.
    always_comb begin
        loc_eff = loc_loop && (mgr_off || mgr_maint);
        rem_eff = rem_loop && !loc_eff;
    end

    // Receive-output selection by priority.
    always_comb begin
        if (bypass) begin
            rx_d = tx_in;
        end else if (loc_eff) begin
            rx_d = tx_path;
        end else begin
            rx_d = rx_in;
        end
    end

    // Receive-output register, cleared by internal reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    // R10: bypass forwards the transmit input.
    a_r10_bypass_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        bypass |=> (rx_q == $past(tx_in)));

    // R8: local loop outside OFF/MAINTENANCE is ignored.
    a_r8_loc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && loc_loop && !mgr_off && !mgr_maint) |=> (rx_q == $past(rx_in)));

    // R9: never both loopbacks in effect.
    a_r9_one_loop: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_eff && rem_eff));

endmodule

// File: rtl/lsl_tx_src.sv
// Module lsl_tx_src
// Builds the transmit path: a fixed line-state symbol or the transmit data
// in maintenance, the transmit data otherwise, and the received symbols
// when remote loopback is in effect. Assumes rem_eff already excludes local
// loopback. Undefined select codes send QUIET.
module lsl_tx_src
    import lsl_pkg::*;
#(
    parameter int               SYM_W      = 10,
    parameter logic [SYM_W-1:0] SYM_QUIET  = 10'h000,
    parameter logic [SYM_W-1:0] SYM_IDLE   = 10'h3FF,
    parameter logic [SYM_W-1:0] SYM_HALT   = 10'h084,
    parameter logic [SYM_W-1:0] SYM_MASTER = 10'h098,
    parameter logic [SYM_W-1:0] SYM_JK     = 10'h311
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mgr_maint,
    input  logic [2:0]       ls_sel,
    input  logic             rem_eff,
    input  logic [SYM_W-1:0] tx_in,
    input  logic [SYM_W-1:0] rx_in,
    output logic [SYM_W-1:0] tx_path,
    output logic [SYM_W-1:0] tx_q
);

    ls_sel_e          sel;
    logic [SYM_W-1:0] maint_sym;
    logic [SYM_W-1:0] tx_d;

    assign sel = ls_sel_e'(ls_sel);

    // Maintenance symbol lookup.
    always_comb begin
        case (sel)
            LS_IDLE:   maint_sym = SYM_IDLE;
            LS_HALT:   maint_sym = SYM_HALT;
            LS_MASTER: maint_sym = SYM_MASTER;
            LS_JK:     maint_sym = SYM_JK;
            LS_PASS:   maint_sym = tx_in;
            default:   maint_sym = SYM_QUIET;
        endcase
    end

    // Transmit path before and after remote loopback.
    always_comb begin
        tx_path = mgr_maint ? maint_sym : tx_in;
        tx_d    = rem_eff ? rx_in : tx_path;
    end

    // Transmit-output register, QUIET under internal reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= SYM_QUIET;
        end else begin
            tx_q <= tx_d;
        end
    end

    // R5: undefined codes send QUIET.
    a_r5_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mgr_maint && !rem_eff && ls_sel[2] && ls_sel[1]) |=> (tx_q == SYM_QUIET));

    // R7: remote loopback forwards the received symbols.
    a_r7_remote_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        rem_eff |=> (tx_q == $past(rx_in)));

    // R6: outside maintenance without loop the transmit data passes.
    a_r6_tx_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgr_maint && !rem_eff) |=> (tx_q == $past(tx_in)));

endmodule

// File: rtl/lsrc_loop_mux.sv
// Module lsrc_loop_mux
// Top of the line-state source and loopback mux: control register, internal
// reset, transmit source selection and receive routing. Assumes the manager
// state flags and select are stable for the cycle they are sampled in.
module lsrc_loop_mux
    import lsl_pkg::*;
#(
    parameter int               SYM_W      = 10,
    parameter logic [SYM_W-1:0] SYM_QUIET  = 10'h000,
    parameter logic [SYM_W-1:0] SYM_IDLE   = 10'h3FF,
    parameter logic [SYM_W-1:0] SYM_HALT   = 10'h084,
    parameter logic [SYM_W-1:0] SYM_MASTER = 10'h098,
    parameter logic [SYM_W-1:0] SYM_JK     = 10'h311
) (
    input  logic             clk,
    input  logic             pwr_rst_n,
    input  logic             ctl_wr_en,
    input  logic [15:0]      ctl_wr_data,
    output logic [15:0]      ctl_rd_data,
    output logic             int_rst_n,
    input  logic             mgr_in_off,
    input  logic             mgr_in_maint,
    input  logic [2:0]       maint_ls_sel,
    input  logic [SYM_W-1:0] tx_sym_in,
    input  logic [SYM_W-1:0] rx_sym_in,
    output logic [SYM_W-1:0] tx_sym_out,
    output logic [SYM_W-1:0] rx_sym_out,
    output logic             fot_off,
    output logic             ext_loop_pin,
    output logic             rpt_filt_en,
    output logic             selftest_run
);

    ctl_t             ctl;
    logic             loc_eff;
    logic             rem_eff;
    logic [SYM_W-1:0] tx_path;

    lsl_ctl_reg u_ctl (
        .clk       (clk),
        .pwr_rst_n (pwr_rst_n),
        .wr_en     (ctl_wr_en),
        .wr_data   (ctl_wr_data),
        .ctl       (ctl),
        .rd_data   (ctl_rd_data),
        .int_rst_n (int_rst_n)
    );

    lsl_tx_src #(
        .SYM_W (SYM_W), .SYM_QUIET (SYM_QUIET), .SYM_IDLE (SYM_IDLE),
        .SYM_HALT (SYM_HALT), .SYM_MASTER (SYM_MASTER), .SYM_JK (SYM_JK)
    ) u_tx (
        .clk       (clk),
        .rst_n     (int_rst_n),
        .mgr_maint (mgr_in_maint),
        .ls_sel    (maint_ls_sel),
        .rem_eff   (rem_eff),
        .tx_in     (tx_sym_in),
        .rx_in     (rx_sym_in),
        .tx_path   (tx_path),
        .tx_q      (tx_sym_out)
    );

    lsl_rx_route #(.SYM_W (SYM_W)) u_rx (
        .clk       (clk),
        .rst_n     (int_rst_n),
        .bypass    (ctl.bypass),
        .loc_loop  (ctl.loc_loop),
        .rem_loop  (ctl.rem_loop),
        .mgr_off   (mgr_in_off),
        .mgr_maint (mgr_in_maint),
        .tx_in     (tx_sym_in),
        .rx_in     (rx_sym_in),
        .tx_path   (tx_path),
        .loc_eff   (loc_eff),
        .rem_eff   (rem_eff),
        .rx_q      (rx_sym_out)
    );

    // Pin-level controls straight from the register.
    always_comb begin
        fot_off      = ctl.tx_off;
        ext_loop_pin = ctl.ext_loop;
        rpt_filt_en  = ctl.rf_en;
        selftest_run = ctl.bist_run;
    end

    // R11: software reset leaves QUIET and zero on the symbol outputs.
    a_r11_outputs_in_reset: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        !int_rst_n |=> (tx_sym_out == SYM_QUIET && rx_sym_out == '0));

endmodule

// File: tb/lsrc_loop_mux_bench.sv
module lsrc_loop_mux_bench;

    logic        clk = 1'b0;
    logic        pwr_rst_n;
    logic        ctl_wr_en;
    logic [15:0] ctl_wr_data;
    logic [15:0] ctl_rd_data;
    logic        int_rst_n;
    logic        mgr_in_off;
    logic        mgr_in_maint;
    logic [2:0]  maint_ls_sel;
    logic [9:0]  tx_sym_in;
    logic [9:0]  rx_sym_in;
    logic [9:0]  tx_sym_out;
    logic [9:0]  rx_sym_out;
    logic        fot_off;
    logic        ext_loop_pin;
    logic        rpt_filt_en;
    logic        selftest_run;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] m_ctl = 16'h0108;

    always #4 clk = ~clk;

    lsrc_loop_mux u_lsrc_loop_mux (
        .clk (clk), .pwr_rst_n (pwr_rst_n), .ctl_wr_en (ctl_wr_en),
        .ctl_wr_data (ctl_wr_data), .ctl_rd_data (ctl_rd_data), .int_rst_n (int_rst_n),
        .mgr_in_off (mgr_in_off), .mgr_in_maint (mgr_in_maint),
        .maint_ls_sel (maint_ls_sel), .tx_sym_in (tx_sym_in), .rx_sym_in (rx_sym_in),
        .tx_sym_out (tx_sym_out), .rx_sym_out (rx_sym_out), .fot_off (fot_off),
        .ext_loop_pin (ext_loop_pin), .rpt_filt_en (rpt_filt_en),
        .selftest_run (selftest_run)
    );

    function automatic logic [9:0] maint_sym(input logic [2:0] s, input logic [9:0] t);
        case (s)
            3'd1: return 10'h3FF;
            3'd2: return 10'h084;
            3'd3: return 10'h098;
            3'd4: return 10'h311;
            3'd5: return t;
            default: return 10'h000;
        endcase
    endfunction

    function automatic logic [15:0] ctl_next(input logic pwr, input logic wr,
                                             input logic [15:0] d, input logic [15:0] cur);
        logic [15:0] n;
        if (!pwr) return 16'h0108;
        n = cur;
        if (wr) n[8] = d[8];
        if (!cur[8]) n[7:0] = 8'h08;
        else if (wr) n[7:0] = d[7:0] & 8'hFD;
        return n;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: compute expectations from current inputs, clock, then compare.
    task automatic step();
        logic in_rst, loc_eff, rem_eff, was_rst;
        logic [9:0] path, ex_tx, ex_rx;
        string ttag, rtag;
        in_rst  = !pwr_rst_n || !m_ctl[8];
        loc_eff = m_ctl[5] && (mgr_in_off || mgr_in_maint);
        rem_eff = m_ctl[4] && !loc_eff;
        path    = mgr_in_maint ? maint_sym(maint_ls_sel, tx_sym_in) : tx_sym_in;
        ex_tx   = in_rst ? 10'h000 : (rem_eff ? rx_sym_in : path);
        ex_rx   = in_rst ? 10'h000 : (m_ctl[3] ? tx_sym_in : (loc_eff ? path : rx_sym_in));
        if (in_rst) ttag = "R11";
        else if (loc_eff && m_ctl[4]) ttag = "R9";
        else if (rem_eff) ttag = "R7";
        else if (mgr_in_maint && maint_ls_sel[2] && maint_ls_sel[1]) ttag = "R5";
        else if (mgr_in_maint) ttag = "R4";
        else ttag = "R6";
        if (in_rst) rtag = "R11";
        else if (m_ctl[3]) rtag = "R10";
        else rtag = "R8";
        was_rst = in_rst;
        m_ctl = ctl_next(pwr_rst_n, ctl_wr_en, ctl_wr_data, m_ctl);
        @(posedge clk);
        @(negedge clk);
        check(ttag, {6'd0, tx_sym_out}, {6'd0, ex_tx});
        check(rtag, {6'd0, rx_sym_out}, {6'd0, ex_rx});
        check(was_rst ? "R2" : "R3", ctl_rd_data, m_ctl);
        check("R3", {12'd0, fot_off, ext_loop_pin, rpt_filt_en, selftest_run},
              {12'd0, m_ctl[7], m_ctl[6], m_ctl[2], m_ctl[0]});
        check("R1", {15'd0, int_rst_n}, {15'd0, pwr_rst_n & m_ctl[8]});
    endtask

    task automatic wr_ctl(input logic [15:0] d);
        ctl_wr_en = 1'b1;
        ctl_wr_data = d;
        step();
        ctl_wr_en = 1'b0;
    endtask

    task automatic rand_data();
        tx_sym_in = 10'($urandom);
        rx_sym_in = 10'($urandom);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        pwr_rst_n = 1'b0; ctl_wr_en = 1'b0; ctl_wr_data = '0;
        mgr_in_off = 1'b0; mgr_in_maint = 1'b0; maint_ls_sel = 3'd0;
        tx_sym_in = 10'h155; rx_sym_in = 10'h2AA;
        @(negedge clk);
        // R2: power reset state
        for (int i = 0; i < 3; i++) step();
        pwr_rst_n = 1'b1;
        step();
        // R3: clear bypass
        wr_ctl(16'h0100);
        // R4 and R5: every maintenance code
        mgr_in_maint = 1'b1;
        for (int s = 0; s < 8; s++) begin
            maint_ls_sel = 3'(s);
            rand_data();
            step();
        end
        // R6: plain pass-through
        mgr_in_maint = 1'b0;
        for (int i = 0; i < 4; i++) begin rand_data(); step(); end
        // R7: remote loopback
        wr_ctl(16'h0110);
        for (int i = 0; i < 4; i++) begin rand_data(); step(); end
        // R8: local loopback ignored, then effective in OFF and MAINTENANCE
        wr_ctl(16'h0120);
        rand_data(); step();
        mgr_in_off = 1'b1; rand_data(); step();
        mgr_in_off = 1'b0; mgr_in_maint = 1'b1; maint_ls_sel = 3'd5; rand_data(); step();
        maint_ls_sel = 3'd2; rand_data(); step();
        // R9: both loopbacks in OFF
        wr_ctl(16'h0130);
        mgr_in_maint = 1'b0; mgr_in_off = 1'b1;
        for (int i = 0; i < 3; i++) begin rand_data(); step(); end
        // R10: bypass over local loopback
        wr_ctl(16'h0128);
        for (int i = 0; i < 3; i++) begin rand_data(); step(); end
        // R3: pins and reserved bits
        wr_ctl(16'hFFFF);
        wr_ctl(16'h01C5);
        // R1 and R11: software reset and a write attempt during it
        wr_ctl(16'h00F5);
        rand_data(); step();
        wr_ctl(16'h00F0);
        rand_data(); step();
        wr_ctl(16'h0130);
        rand_data(); step();
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            rand_data();
            mgr_in_off   = ($urandom % 3) == 0;
            mgr_in_maint = ($urandom % 3) == 0;
            maint_ls_sel = 3'($urandom);
            pwr_rst_n    = ($urandom % 300) != 0;
            ctl_wr_en    = ($urandom % 8) == 0;
            ctl_wr_data  = 16'($urandom);
            if (($urandom % 6) != 0) ctl_wr_data[8] = 1'b1;
            step();
        end
        ctl_wr_en = 1'b0; pwr_rst_n = 1'b1;
        step();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule